// File: doc/BRIEF.md
# Two-Level Chip-Select Decoder for a 16-bit Address Bus

This block turns the address of an 8-bit processor with a 64 KB address space into active-low chip selects. The upper 32 KB is cut into eight 4 KB chunks. The first four chunks form a common RAM area spread over two 8 KB devices. The next chunk is an expansion window and the one after it is the I/O window. The last two chunks together hold one EEPROM. A second decoder splits the I/O window into sixteen 256-byte device slots. Slot 0 belongs to the control registers of the banked-memory mapper.

Accesses to the lower 32 KB produce no chip select. They raise an active-high banked flag instead, which hands the access to the separate banked-RAM mapper. A valid input qualifies every access. The decoded selects are registered, so every output follows its address by exactly one clock.

Top module: `addr_decoder`

## Requirements
- R1: While reset is held, every select output is high (deasserted) and `banked_hit` is low, whatever the address and valid inputs are.
- R2: If `access_valid` was low at a clock edge, then after that edge every select is high and `banked_hit` is low.
- R3: A valid access with address bit 15 low raises `banked_hit` and leaves every select high.
- R4: A valid access in $8000–$9FFF drives `ram_cs_n[0]` low. A valid access in $A000–$BFFF drives `ram_cs_n[1]` low. Address bit 13 picks the device.
- R5: A valid access in $C000–$CFFF drives `exp_cs_n` low.
- R6: A valid access anywhere in $E000–$FFFF drives `eeprom_cs_n` low.
- R7: A valid access in $D000–$DFFF drives `io_cs_n[k]` low, where k is address bits 11..8, and leaves the other fifteen slot selects high.
- R8: The mapper control registers at $D000–$D0FF are reached through `io_cs_n[0]` alone.
- R9: For every valid address exactly one of the 21 indications is active: the 20 selects and `banked_hit`. With no valid access none of them is active.
- R10: Outputs are registered. A new address shows on the outputs after the next rising clock edge, and the outputs do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Processor address |
| access_valid | input | 1 | High when the address is a real memory access |
| ram_cs_n | output | 2 | Common RAM device selects, active low |
| exp_cs_n | output | 1 | Expansion window select, active low |
| eeprom_cs_n | output | 1 | EEPROM select, active low |
| io_cs_n | output | 16 | I/O device slot selects, active low |
| banked_hit | output | 1 | High for a valid access to the lower 32 KB |

## Verification
The bench walks all 65536 addresses. This exposes chunk boundaries such as $7FFF/$8000, $9FFF/$A000, $CFFF/$D000 and $DFFF/$E000. A decoder that used the wrong address bit there would fire the neighbouring select, or two selects at once. Within the I/O window it checks every slot edge, so a slot index taken from the wrong nibble lands on the wrong device. A sweep with the valid input low catches selects that leak out without a real access. A check taken between the address change and the next edge catches outputs that were not registered. The two merged chunks of the EEPROM are checked so that $E000–$EFFF is not left without a select.

// File: rtl/addr_decoder_pkg.sv
package addr_decoder_pkg;
    localparam int ADDR_W     = 16;
    localparam int CHUNK_W    = 3;
    localparam int SLOT_W     = 4;
    localparam int RAM_CHIPS  = 2;
    localparam int N_CHUNKS   = 1 << CHUNK_W;
    localparam int IO_SLOTS   = 1 << SLOT_W;
    localparam int CHUNK_LSB  = ADDR_W - 1 - CHUNK_W;   // 12
    localparam int SLOT_LSB   = CHUNK_LSB - SLOT_W;     // 8
    localparam int RAM_SEL_B  = CHUNK_LSB + 1;          // 13
    localparam int RAM_LAST   = 3;                      // chunks 0..3
    localparam int EXP_CHUNK  = 4;
    localparam int IO_CHUNK   = 5;
    localparam int ROM_FIRST  = 6;                      // chunks 6..7

    typedef struct packed {
        logic [RAM_CHIPS-1:0] ram_n;
        logic                 exp_n;
        logic                 rom_n;
        logic [IO_SLOTS-1:0]  io_n;
        logic                 banked;
        logic                 live;
    } sel_t;

    localparam sel_t SEL_IDLE = '{
        ram_n : '1, exp_n : 1'b1, rom_n : 1'b1,
        io_n : '1, banked : 1'b0, live : 1'b0
    };
endpackage

// File: rtl/addr_chunk_decode.sv
module addr_chunk_decode #(
    parameter int SEL_W = 3,
    localparam int N_OUT = 1 << SEL_W
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [N_OUT-1:0] hit
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_hit
        assign hit[i] = en && (sel == SEL_W'(i));
    end

    always_comb begin
        if (!en) assert_quiet_when_off_R9: assert (hit == '0);
        else     assert_single_hit_R9: assert ($onehot(hit));
    end
endmodule

// File: rtl/addr_decoder.sv
module addr_decoder
    import addr_decoder_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 access_valid,
    output logic [RAM_CHIPS-1:0] ram_cs_n,
    output logic                 exp_cs_n,
    output logic                 eeprom_cs_n,
    output logic [IO_SLOTS-1:0]  io_cs_n,
    output logic                 banked_hit
);
    logic                upper_en;
    logic                io_en;
    logic [N_CHUNKS-1:0] chunk_hit;
    logic [IO_SLOTS-1:0] slot_hit;
    sel_t                sel_d, sel_q;

    assign upper_en = access_valid && addr[ADDR_W-1];

    addr_chunk_decode #(.SEL_W(CHUNK_W)) u_chunk (
        .en  (upper_en),
        .sel (addr[CHUNK_LSB +: CHUNK_W]),
        .hit (chunk_hit)
    );

    assign io_en = chunk_hit[IO_CHUNK];

    addr_chunk_decode #(.SEL_W(SLOT_W)) u_slot (
        .en  (io_en),
        .sel (addr[SLOT_LSB +: SLOT_W]),
        .hit (slot_hit)
    );

    always_comb begin
        logic ram_area;
        logic rom_area;
        sel_d = SEL_IDLE;
        sel_d.live = 1'b1;
        ram_area = |chunk_hit[RAM_LAST:0];
        rom_area = |chunk_hit[N_CHUNKS-1:ROM_FIRST];
        for (int c = 0; c < RAM_CHIPS; c++) begin
            sel_d.ram_n[c] = !(ram_area && (addr[RAM_SEL_B] == c[0]));
        end
        sel_d.exp_n  = !chunk_hit[EXP_CHUNK];
        sel_d.rom_n  = !rom_area;
        sel_d.io_n   = ~slot_hit;
        sel_d.banked = access_valid && !addr[ADDR_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= SEL_IDLE;
        else        sel_q <= sel_d;
    end

    assign ram_cs_n    = sel_q.ram_n;
    assign exp_cs_n    = sel_q.exp_n;
    assign eeprom_cs_n = sel_q.rom_n;
    assign io_cs_n     = sel_q.io_n;
    assign banked_hit  = sel_q.banked;

    logic [IO_SLOTS+RAM_CHIPS+2:0] act_vec;
    assign act_vec = {~ram_cs_n, ~exp_cs_n, ~eeprom_cs_n, ~io_cs_n, banked_hit};

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (&ram_cs_n && exp_cs_n && eeprom_cs_n && &io_cs_n && !banked_hit));

    assert_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q.live && !$past(access_valid) |-> act_vec == '0);

    assert_banked_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q.live && $past(access_valid) && !$past(addr[ADDR_W-1])
            |-> banked_hit && $countones(act_vec) == 1);

    assert_ram_chip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q.live && !ram_cs_n[1] |-> $past(addr[ADDR_W-1 -: 3]) == 3'b101);

    assert_rom_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q.live && !eeprom_cs_n |-> $past(addr[ADDR_W-1 -: 3]) == 3'b111);

    assert_io_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~io_cs_n));

    assert_exactly_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q.live && $past(access_valid) |-> $countones(act_vec) == 1);
endmodule

// File: tb/addr_decoder_test.sv
module addr_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        access_valid = 1'b0;
    logic [1:0]  ram_cs_n;
    logic        exp_cs_n;
    logic        eeprom_cs_n;
    logic [15:0] io_cs_n;
    logic        banked_hit;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    addr_decoder uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .access_valid(access_valid),
        .ram_cs_n(ram_cs_n), .exp_cs_n(exp_cs_n), .eeprom_cs_n(eeprom_cs_n),
        .io_cs_n(io_cs_n), .banked_hit(banked_hit)
    );

    // active-high view: {ram[1:0], exp, rom, io[15:0], banked}
    function automatic logic [20:0] model(input logic [15:0] a, input logic v);
        logic [20:0] e = '0;
        int unsigned x = a;
        if (v) begin
            if (x < 32'h8000)       e[0] = 1'b1;
            else if (x < 32'hA000)  e[19] = 1'b1;
            else if (x < 32'hC000)  e[20] = 1'b1;
            else if (x < 32'hD000)  e[18] = 1'b1;
            else if (x < 32'hE000)  e[1 + (x - 32'hD000) / 256] = 1'b1;
            else                    e[17] = 1'b1;
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [15:0] a, input logic v);
        int unsigned x = a;
        if (!v)                return "R2";
        if (x < 32'h8000)      return "R3";
        if (x < 32'hC000)      return "R4";
        if (x < 32'hD000)      return "R5";
        if (x < 32'hD100)      return "R8";
        if (x < 32'hE000)      return "R7";
        return "R6";
    endfunction

    function automatic logic [20:0] seen();
        return {~ram_cs_n, ~exp_cs_n, ~eeprom_cs_n, ~io_cs_n, banked_hit};
    endfunction

    task automatic check(input string tag, input logic [20:0] exp_v, input logic [15:0] a);
        logic [20:0] got = seen();
        n_checks++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%b expected=%b", tag, a, got, exp_v);
        end
    endtask

    task automatic count_one(input logic [15:0] a);
        n_checks++;
        if ($countones(seen()) != 1) begin
            n_fail++;
            $display("FAIL R9 addr=%h actual=%0d expected=1 active", a, $countones(seen()));
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic v);
        @(negedge clk);
        addr = a;
        access_valid = v;
        @(negedge clk);
        check(tag_of(a, v), model(a, v), a);
        if (v) count_one(a);
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset holds outputs idle even with a live access
        addr = 16'h8000;
        access_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", '0, addr);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: no change before the edge, change after it
        addr = 16'hE000;
        access_valid = 1'b1;
        @(negedge clk);
        check("R10", model(16'hE000, 1'b1), 16'hE000);
        addr = 16'h1234;
        #1;
        check("R10", model(16'hE000, 1'b1), 16'h1234);
        @(negedge clk);
        check("R10", model(16'h1234, 1'b1), 16'h1234);

        // corner addresses
        apply(16'h7FFF, 1'b1);
        apply(16'h8000, 1'b1);
        apply(16'h9FFF, 1'b1);
        apply(16'hA000, 1'b1);
        apply(16'hCFFF, 1'b1);
        apply(16'hD000, 1'b1);
        apply(16'hD0FF, 1'b1);
        apply(16'hD100, 1'b1);
        apply(16'hDFFF, 1'b1);
        apply(16'hE000, 1'b1);
        apply(16'hEFFF, 1'b1);
        apply(16'hFFFF, 1'b1);

        // R2: valid low across the map
        for (int i = 0; i < 256; i++) apply(16'(i * 257), 1'b0);

        // full sweep, R3..R9
        for (int i = 0; i < 65536; i++) apply(16'(i), 1'b1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule